// File: doc/BRIEF.md
# Slippable 8-to-66 Bit Receive Gearbox

This block sits at the front of a 64b/66b receive path. On every clock it takes one 8-bit word from a deserializer and packs the bits into 66-bit words. Each finished word leaves on a registered output with a one-cycle valid strobe. The input is always valid and the output is always accepted, so there is no handshake in either direction.

A separate aligner closes the loop through the slip input. Each clock with slip high drops one bit from the incoming stream, which moves every later word boundary by one bit. The aligner keeps slipping until the two header bits of each word look right.

Three line-side controls sit around the packing logic:
- An inversion control flips all eight incoming bits, which corrects a swapped differential pair.
- An input order control reverses each byte before it is packed.
- An output order control reverses the finished 66-bit word.

The two order controls act independently of each other.

Top module: `gbx8to66`

## Requirements
- R1: Synchronous reset empties the buffer and forces `dout_vld` and `dout` to 0. After reset is released, the first valid word appears on the 9th clock that delivers a byte, because 9 × 8 = 72 ≥ 66 and 8 × 8 = 64 < 66. Bytes accepted before a reset never appear afterwards.
- R2: With both order controls at 0, bit j of a valid word is the j-th oldest conditioned bit not yet emitted or dropped. The conditioned stream takes bit 0 of each conditioned byte first. Bits 65:64 are therefore the last two bits in stream order and carry the sync header; bits 63:0 carry the payload.
- R3: `dout_vld` is high in the cycle after a clock at which at least 66 bits are buffered. That count includes the byte just accepted and excludes any bit just dropped. After each clock the buffer holds fewer than 66 bits, so valid is never high in two consecutive cycles. Without slips, 264 bytes give exactly 32 words.
- R4: When `invert` is 1, every bit of the input byte is complemented before packing. When it is 0, the byte passes unchanged.
- R5: When `rev_in` is 1, conditioned byte bit i is taken from input bit 7-i.
- R6: When `rev_out` is 1, `dout[j]` holds word bit 65-j, independently of `rev_in`. The control acts on the registered word without added delay.
- R7: Each clock with `slip` high discards exactly one bit: the oldest bit not yet emitted, counted after the byte of that clock has been appended. Holding `slip` high for n clocks discards n bits.
- R8: A repeating 66-bit frame entered at a bit offset k (stream bit s = frame bit (s+k) mod 66) is output exactly, word after word, once (66-k) mod 66 slips have been applied. One slip fewer does not reproduce it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 8 | Deserialized byte, one per clock |
| slip | input | 1 | Drop one bit this clock |
| invert | input | 1 | Complement incoming bits |
| rev_in | input | 1 | Reverse bit order of each input byte |
| rev_out | input | 1 | Reverse bit order of the output word |
| dout | output | 66 | Output word; 65:64 header, 63:0 payload |
| dout_vld | output | 1 | Output word valid strobe |

## Verification
The bench builds the block with its default widths of 8 in and 66 out. Because 66 is not a multiple of 8, the buffer occupancy after each clock takes every even residue below 66 in turn. Slip runs of odd length also reach every odd residue, so each extraction case of the 74-bit buffer is exercised. A slip count of 43 aligns a frame entered at offset 23, which tests boundary recovery at an odd offset that lies neither at a byte edge nor near zero.

// File: rtl/gbx_pkg.sv
`timescale 1ns/1ps
package gbx_pkg;
    localparam int GBX_IN_W  = 8;
    localparam int GBX_OUT_W = 66;

    typedef struct packed {
        logic invert;
        logic rev_in;
        logic rev_out;
    } gbx_ctrl_t;
endpackage

// File: rtl/gbx_in_cond.sv
`timescale 1ns/1ps
// Line-side conditioning of one narrow word: optional reversal, then inversion.
module gbx_in_cond #(
    parameter int IN_W = 8
) (
    input  logic [IN_W-1:0] raw,
    input  logic            invert,
    input  logic            rev,
    output logic [IN_W-1:0] cond
);
    for (genvar i = 0; i < IN_W; i++) begin : g_bit
        assign cond[i] = invert ^ (rev ? raw[IN_W-1-i] : raw[i]);
    end
endmodule

// File: rtl/gbx_pack.sv
`timescale 1ns/1ps
// Bit buffer with fill count: append, optional single-bit drop, extract.
module gbx_pack #(
    parameter int IN_W  = 8,
    parameter int OUT_W = 66
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IN_W-1:0]  bits_in,
    input  logic             slip,
    output logic [OUT_W-1:0] word,
    output logic             word_vld,
    output logic [$clog2(OUT_W+IN_W+1)-1:0] occ
);
    localparam int BUF_W = OUT_W + IN_W;
    localparam int CNT_W = $clog2(BUF_W + 1);
    localparam int PAD_W = BUF_W - IN_W;

    typedef struct packed {
        logic [BUF_W-1:0] sbuf;
        logic [CNT_W-1:0] fill;
        logic             vld;
        logic [OUT_W-1:0] word;
    } pk_t;

    pk_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.vld  = 1'b0;
        // append the new bits just above the oldest held bits
        st_d.sbuf = st_q.sbuf | ({{PAD_W{1'b0}}, bits_in} << st_q.fill);
        st_d.fill = st_q.fill + CNT_W'(IN_W);
        // drop the oldest bit; fill is at least IN_W here
        if (slip) begin
            st_d.sbuf = st_d.sbuf >> 1;
            st_d.fill = st_d.fill - CNT_W'(1);
        end
        if (st_d.fill >= CNT_W'(OUT_W)) begin
            st_d.vld  = 1'b1;
            st_d.word = st_d.sbuf[OUT_W-1:0];
            st_d.sbuf = st_d.sbuf >> OUT_W;
            st_d.fill = st_d.fill - CNT_W'(OUT_W);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign word     = st_q.word;
    assign word_vld = st_q.vld;
    assign occ      = st_q.fill;
endmodule

// File: rtl/gbx_out_order.sv
`timescale 1ns/1ps
// Optional reversal of the wide output word.
module gbx_out_order #(
    parameter int OUT_W = 66
) (
    input  logic [OUT_W-1:0] word,
    input  logic             rev,
    output logic [OUT_W-1:0] dout
);
    for (genvar j = 0; j < OUT_W; j++) begin : g_bit
        assign dout[j] = rev ? word[OUT_W-1-j] : word[j];
    end
endmodule

// File: rtl/gbx8to66.sv
`timescale 1ns/1ps
module gbx8to66
    import gbx_pkg::*;
#(
    parameter int IN_W  = GBX_IN_W,
    parameter int OUT_W = GBX_OUT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IN_W-1:0]  din,
    input  logic             slip,
    input  logic             invert,
    input  logic             rev_in,
    input  logic             rev_out,
    output logic [OUT_W-1:0] dout,
    output logic             dout_vld
);
    localparam int CNT_W = $clog2(OUT_W + IN_W + 1);

    gbx_ctrl_t        ctl;
    logic [IN_W-1:0]  cond;
    logic [OUT_W-1:0] word;
    logic [CNT_W-1:0] occ;

    assign ctl = '{invert: invert, rev_in: rev_in, rev_out: rev_out};

    gbx_in_cond #(.IN_W(IN_W)) u_cond (
        .raw    (din),
        .invert (ctl.invert),
        .rev    (ctl.rev_in),
        .cond   (cond)
    );

    gbx_pack #(.IN_W(IN_W), .OUT_W(OUT_W)) u_pack (
        .clk      (clk),
        .rst      (rst),
        .bits_in  (cond),
        .slip     (slip),
        .word     (word),
        .word_vld (dout_vld),
        .occ      (occ)
    );

    gbx_out_order #(.OUT_W(OUT_W)) u_ord (
        .word (word),
        .rev  (ctl.rev_out),
        .dout (dout)
    );
endmodule

// File: rtl/gbx8to66_chk.sv
`timescale 1ns/1ps
module gbx8to66_chk #(
    parameter int IN_W  = 8,
    parameter int OUT_W = 66
) (
    input logic                               clk,
    input logic                               rst,
    input logic                               slip,
    input logic                               vld,
    input logic [$clog2(OUT_W+IN_W+1)-1:0]    occ
);
    // R1: first cycle out of reset carries no word
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !vld);

    // R3: never two words in a row
    a_r3_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        vld |=> !vld);

    // R3: buffer holds less than a word after every clock
    a_r3_below_word: assert property (@(posedge clk) disable iff (rst)
        int'(occ) < OUT_W);

    // R3 / R7: occupancy grows by one byte less any dropped bit when no word leaves
    a_r7_fill_step: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !vld) |->
        int'(occ) == int'($past(occ)) + IN_W - int'($past(slip)));

    // R3 / R7: a word leaving removes exactly one word of bits
    a_r3_fill_extract: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && vld) |->
        int'(occ) + OUT_W == int'($past(occ)) + IN_W - int'($past(slip)));
endmodule

bind gbx8to66 gbx8to66_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .slip (slip),
    .vld  (dout_vld),
    .occ  (occ)
);

// File: tb/gbx8to66_tb.sv
`timescale 1ns/1ps
module gbx8to66_tb;
    localparam int IN_W  = 8;
    localparam int OUT_W = 66;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [IN_W-1:0]  din = '0;
    logic             slip = 1'b0;
    logic             invert = 1'b0;
    logic             rev_in = 1'b0;
    logic             rev_out = 1'b0;
    logic [OUT_W-1:0] dout;
    logic             dout_vld;

    int n_chk = 0;
    int n_fail = 0;
    bit st [0:16383];
    int pushed = 0;
    int taken = 0;
    int words = 0;

    // fields: [15] invert [14] rev_in [13] rev_out [12:8] slips [7:0] seed
    localparam logic [15:0] SCN [0:5] = '{
        {1'b0, 1'b0, 1'b0, 5'd0,  8'h5A},
        {1'b1, 1'b0, 1'b0, 5'd0,  8'h13},
        {1'b0, 1'b1, 1'b0, 5'd0,  8'hC7},
        {1'b0, 1'b0, 1'b1, 5'd0,  8'h2E},
        {1'b1, 1'b1, 1'b1, 5'd3,  8'h91},
        {1'b0, 1'b0, 1'b0, 5'd17, 8'h08}
    };
    localparam logic [65:0] FRAME = {2'b01, 64'hDEAD_BEEF_0123_A5C3};

    gbx8to66 #(.IN_W(IN_W), .OUT_W(OUT_W)) u_dut (
        .clk(clk), .rst(rst), .din(din), .slip(slip), .invert(invert),
        .rev_in(rev_in), .rev_out(rev_out), .dout(dout), .dout_vld(dout_vld)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [65:0] act, input logic [65:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; slip = 1'b0; din = '0;
        repeat (2) @(negedge clk);
        check(dout_vld == 1'b0, "R1", "valid in reset", 66'(dout_vld), 66'(0));
        check(dout == '0, "R1", "word in reset", dout, '0);
        rst = 1'b0;
        pushed = 0; taken = 0; words = 0;
    endtask

    // called at a negedge; applies one byte, then checks the result of that edge
    task automatic drive(input logic [7:0] b, input bit s, input string req);
        logic [65:0] w;
        logic [65:0] e;
        bit ev;
        din = b; slip = s;
        for (int i = 0; i < IN_W; i++)
            st[pushed + i] = invert ^ (rev_in ? b[IN_W-1-i] : b[i]);
        pushed += IN_W;
        if (s) taken++;
        @(negedge clk);
        ev = (pushed - taken) >= OUT_W;
        check(dout_vld == ev, "R3", "valid timing", 66'(dout_vld), 66'(ev));
        if (ev) begin
            for (int j = 0; j < OUT_W; j++) w[j] = st[taken + j];
            for (int j = 0; j < OUT_W; j++) e[j] = rev_out ? w[OUT_W-1-j] : w[j];
            check(dout == e, req, "word content", dout, e);
            taken += OUT_W;
            words++;
        end
    endtask

    initial begin
        #(100000 * 10);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        string tags [0:5] = '{"R2", "R4", "R5", "R6", "R7", "R7"};
        @(negedge clk);

        // table of scenarios
        for (int k = 0; k < 6; k++) begin
            int ns;
            invert  = SCN[k][15];
            rev_in  = SCN[k][14];
            rev_out = SCN[k][13];
            ns      = int'(SCN[k][12:8]);
            do_reset();
            for (int c = 0; c < 264; c++)
                drive(8'(c * 37 + int'(SCN[k][7:0])) ^ 8'(c >> 3),
                      (c >= 2) && (c < 2 + ns), tags[k]);
            check(words == (2112 - ns) / 66, "R3", "word count",
                  66'(words), 66'((2112 - ns) / 66));
        end

        // R1: first word arrives on the 9th byte
        invert = 1'b0; rev_in = 1'b0; rev_out = 1'b0;
        do_reset();
        for (int c = 0; c < 8; c++) begin
            drive(8'hA5 ^ 8'(c), 1'b0, "R1");
            check(dout_vld == 1'b0, "R1", "early valid", 66'(dout_vld), 66'(0));
        end
        drive(8'h3C, 1'b0, "R1");
        check(dout_vld == 1'b1, "R1", "ninth byte valid", 66'(dout_vld), 66'(1));

        // R1: reset mid-stream discards buffered bits
        for (int c = 0; c < 13; c++) drive(8'hFF, 1'b0, "R1");
        do_reset();
        for (int c = 0; c < 9; c++) drive(8'h00, 1'b0, "R1");
        check(dout_vld == 1'b1 && dout == '0, "R1", "no stale bits after reset",
              dout, '0);

        // R8: frame at offset 23 recovered by 43 slips, not by 42
        for (int t = 0; t < 2; t++) begin
            int nsl;
            int good;
            nsl = (t == 0) ? 43 : 42;
            good = 0;
            do_reset();
            for (int c = 0; c < 300; c++) begin
                logic [7:0] b;
                for (int i = 0; i < IN_W; i++) b[i] = FRAME[(8 * c + i + 23) % 66];
                drive(b, c < nsl, "R8");
                if (c > 60 && dout_vld) begin
                    if (t == 0) check(dout == FRAME, "R8", "aligned frame", dout, FRAME);
                    else if (dout == FRAME) good++;
                end
            end
            if (t == 1) check(good == 0, "R8", "one slip short still aligned",
                              66'(good), 66'(0));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule